// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects a bank of level-sensitive interrupt request lines, holds their current levels in a raw-level register and gates them with a software-controlled enable mask. Every enabled source that is pending is merged into a single cascade output. That output feeds one input of a primary vectored controller. The block also has an upper band of lines, 21 to 30 by default, that can be routed one-for-one to matching direct outputs toward the same primary controller. This routing is governed by a separate pass-through enable register, and it skips the merge so that these sources keep their own priority slot upstream.

Software reaches the block over a plain word-addressed register port: a byte address, a write strobe, write data and combinational read data. The enable mask and the pass-through enables each use set and clear words, so no read-modify-write is needed. A soft-interrupt pair of words controls mask bit 0 alone. All outputs are registered and follow their inputs with one cycle of latency.

Top module: `irqsec_top`

## Requirements
- R1: After a synchronous active-low reset the enable mask and the pass-through enable register are zero and every output bit is low.
- R2: The register word is the byte address shifted right by two. Word 1 reads the sampled raw levels, word 0 reads the raw levels ANDed with the enable mask, and word 2 reads the enable mask.
- R3: A write to word 2 ORs the write data into the enable mask. A write to word 3 clears each mask bit whose write-data bit is 1 and keeps the others.
- R4: Word 4 reads bit 0 of the raw level, with all other bits zero. A nonzero write to word 4 sets mask bit 0 and a nonzero write to word 5 clears it. A zero write to either word leaves the mask unchanged.
- R5: A write to word 8 ORs into the pass-through enable register only the write-data bits in 21..30 (value 0x7FE00000). Word 8 reads that register.
- R6: A write to word 9 clears each pass-through enable bit whose write-data bit is 1.
- R7: Output bit 31 is high one cycle after an input sample in which any input bit and its mask bit are both 1, and low otherwise.
- R8: For each i in 21..30, output bit i equals input bit i one cycle later when pass-through enable bit i is set, and is low when it is clear. Output bits 0..20 are always low.
- R9: Reads of words 6, 7 and 10 through 1023 return zero, and writes to them change neither the mask nor the pass-through enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt request lines |
| bus_addr | input | 12 | Byte address in the 4 KB register window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 32 | Lines to the primary controller: bit 31 cascade, 21..30 pass-through |

## Verification
The assertions assume irq_in and the bus inputs are stable across each rising edge, and that bus_wr lasts a single cycle per access, since each check compares state one cycle after the cycle that caused it. The stimulus changes every input just after a falling edge and holds it for a full period, so each edge sees settled values. The sweeps walk a single set bit and a single clear bit across all 32 lines, under both narrow and full masks, and they cover every undefined word in the low part of the window plus the top word.

// File: rtl/irqsec_pkg.sv
// Package: shared constants for the secondary interrupt controller.
// Holds the register word indices that software decodes; these indices
// are fixed by the register map and are not meant to be changed.
package irqsec_pkg;

    // Register word indices (byte address >> 2)
    localparam int unsigned WORD_STATUS  = 0;  // masked pending, read
    localparam int unsigned WORD_RAW     = 1;  // raw level, read
    localparam int unsigned WORD_ENSET   = 2;  // mask read / OR-in write
    localparam int unsigned WORD_ENCLR   = 3;  // mask clear write
    localparam int unsigned WORD_SOFTSET = 4;  // bit0 raw read / mask0 set
    localparam int unsigned WORD_SOFTCLR = 5;  // mask0 clear write
    localparam int unsigned WORD_PTSET   = 8;  // pass-through read / set
    localparam int unsigned WORD_PTCLR   = 9;  // pass-through clear

    // Decoded register operation for one bus cycle
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic soft_set;
        logic soft_clr;
        logic pt_set;
        logic pt_clr;
    } wr_op_t;

endpackage

// File: rtl/irqsec_decode.sv
// Module: irqsec_decode
// Purpose: turns a byte address and write strobe into one-hot register
// write operations and a read-select word index.
// Assumes: bus_addr is a byte address; the two low bits are ignored.
module irqsec_decode #(
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned WORD_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [31:0]               bus_wdata,
    output logic [WORD_W-1:0]         word_idx,
    output irqsec_pkg::wr_op_t        wr_op,
    output logic                      wdata_nz,
    output logic                      undef_word
);
    import irqsec_pkg::*;

    localparam logic [WORD_W-1:0] SEL_STATUS  = WORD_W'(WORD_STATUS);
    localparam logic [WORD_W-1:0] SEL_RAW     = WORD_W'(WORD_RAW);
    localparam logic [WORD_W-1:0] SEL_ENSET   = WORD_W'(WORD_ENSET);
    localparam logic [WORD_W-1:0] SEL_ENCLR   = WORD_W'(WORD_ENCLR);
    localparam logic [WORD_W-1:0] SEL_SOFTSET = WORD_W'(WORD_SOFTSET);
    localparam logic [WORD_W-1:0] SEL_SOFTCLR = WORD_W'(WORD_SOFTCLR);
    localparam logic [WORD_W-1:0] SEL_PTSET   = WORD_W'(WORD_PTSET);
    localparam logic [WORD_W-1:0] SEL_PTCLR   = WORD_W'(WORD_PTCLR);

    logic unused_byte_lanes;
    assign unused_byte_lanes = &{1'b0, bus_addr[1:0]};

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign wdata_nz = |bus_wdata;

    // Purpose: flag words with no defined register behind them.
    always_comb begin
        unique case (word_idx)
            SEL_STATUS, SEL_RAW, SEL_ENSET, SEL_ENCLR,
            SEL_SOFTSET, SEL_SOFTCLR, SEL_PTSET, SEL_PTCLR: undef_word = 1'b0;
            default:                                        undef_word = 1'b1;
        endcase
    end

    // Purpose: one-hot write operation for the addressed register word.
    always_comb begin
        wr_op          = '0;
        wr_op.en_set   = bus_wr && (word_idx == SEL_ENSET);
        wr_op.en_clr   = bus_wr && (word_idx == SEL_ENCLR);
        wr_op.soft_set = bus_wr && (word_idx == SEL_SOFTSET) && wdata_nz;
        wr_op.soft_clr = bus_wr && (word_idx == SEL_SOFTCLR) && wdata_nz;
        wr_op.pt_set   = bus_wr && (word_idx == SEL_PTSET);
        wr_op.pt_clr   = bus_wr && (word_idx == SEL_PTCLR);
    end

endmodule

// File: rtl/irqsec_regs.sv
// Module: irqsec_regs
// Purpose: holds the raw-level sample, the enable mask and the
// pass-through enable register, and returns read data.
// Assumes: wr_op comes from irqsec_decode and is one-hot or zero.
module irqsec_regs #(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned PT_LO   = 21,
    parameter int unsigned PT_HI   = 30,
    localparam int unsigned WORD_W = ADDR_W - 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        irq_in,
    input  logic [NUM_IRQ-1:0]        wdata,
    input  logic [WORD_W-1:0]         word_idx,
    input  irqsec_pkg::wr_op_t        wr_op,
    input  logic                      wdata_nz,
    input  logic                      undef_word,
    input  logic                      bus_wr,
    output logic [NUM_IRQ-1:0]        raw_q,
    output logic [NUM_IRQ-1:0]        mask_q,
    output logic [NUM_IRQ-1:0]        pt_q,
    output logic [NUM_IRQ-1:0]        rdata
);
    import irqsec_pkg::*;

    localparam logic [NUM_IRQ-1:0] ONE     = NUM_IRQ'(1);
    localparam logic [NUM_IRQ-1:0] PT_MASK = (ONE << (PT_HI + 1)) - (ONE << PT_LO);

    logic [NUM_IRQ-1:0] mask_nxt;
    logic [NUM_IRQ-1:0] pt_nxt;

    // Purpose: per-bit next state of the enable mask and pass-through enables.
    for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
        if (b == 0) begin : g_soft
            always_comb begin
                mask_nxt[b] = mask_q[b];
                if (wr_op.en_set && wdata[b]) mask_nxt[b] = 1'b1;
                if (wr_op.en_clr && wdata[b]) mask_nxt[b] = 1'b0;
                if (wr_op.soft_set)           mask_nxt[b] = 1'b1;
                if (wr_op.soft_clr)           mask_nxt[b] = 1'b0;
            end
        end else begin : g_norm
            always_comb begin
                mask_nxt[b] = mask_q[b];
                if (wr_op.en_set && wdata[b]) mask_nxt[b] = 1'b1;
                if (wr_op.en_clr && wdata[b]) mask_nxt[b] = 1'b0;
            end
        end
        if ((b >= PT_LO) && (b <= PT_HI)) begin : g_pt
            always_comb begin
                pt_nxt[b] = pt_q[b];
                if (wr_op.pt_set && wdata[b]) pt_nxt[b] = 1'b1;
                if (wr_op.pt_clr && wdata[b]) pt_nxt[b] = 1'b0;
            end
        end else begin : g_nopt
            assign pt_nxt[b] = 1'b0;
        end
    end

    // Purpose: sample the input levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= irq_in;
    end

    // Purpose: update the software-visible enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pt_q   <= '0;
        end else begin
            mask_q <= mask_nxt;
            pt_q   <= pt_nxt;
        end
    end

    // Purpose: read-data multiplexer; undefined words read zero.
    always_comb begin
        unique case (word_idx)
            WORD_W'(WORD_STATUS):  rdata = raw_q & mask_q;
            WORD_W'(WORD_RAW):     rdata = raw_q;
            WORD_W'(WORD_ENSET):   rdata = mask_q;
            WORD_W'(WORD_SOFTSET): rdata = raw_q & ONE;
            WORD_W'(WORD_PTSET):   rdata = pt_q;
            default:               rdata = '0;
        endcase
    end

    AST_ENSET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op.en_set |=> ((mask_q & $past(wdata)) == $past(wdata))); // R3
    AST_ENSET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op.en_set |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R3
    AST_ENCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op.en_clr |=> ((mask_q & $past(wdata)) == '0)); // R3
    AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && word_idx == WORD_W'(WORD_SOFTSET) && wdata_nz) |=> mask_q[0]); // R4
    AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && word_idx == WORD_W'(WORD_SOFTCLR) && wdata_nz) |=> !mask_q[0]); // R4
    AST_SOFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wdata_nz && (word_idx == WORD_W'(WORD_SOFTSET) ||
         word_idx == WORD_W'(WORD_SOFTCLR))) |=> $stable(mask_q)); // R4
    AST_PT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op.pt_set |=> ((pt_q & ~PT_MASK) == '0)); // R5
    AST_PT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op.pt_clr |=> ((pt_q & $past(wdata)) == '0)); // R6
    AST_UNDEF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && undef_word) |=> ($stable(mask_q) && $stable(pt_q))); // R9
    AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        undef_word |-> (rdata == '0)); // R9

endmodule

// File: rtl/irqsec_route.sv
// Module: irqsec_route
// Purpose: builds the registered output lines: a cascade OR of all
// enabled pending inputs on the top line and one-for-one pass-through
// lines for the configured band.
// Assumes: CASC_IDX lies outside PT_LO..PT_HI.
module irqsec_route #(
    parameter int unsigned NUM_IRQ  = 32,
    parameter int unsigned PT_LO    = 21,
    parameter int unsigned PT_HI    = 30,
    parameter int unsigned CASC_IDX = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_in,
    input  logic [NUM_IRQ-1:0]   mask_q,
    input  logic [NUM_IRQ-1:0]   pt_q,
    output logic [NUM_IRQ-1:0]   irq_out
);
    localparam logic [NUM_IRQ-1:0] ONE     = NUM_IRQ'(1);
    localparam logic [NUM_IRQ-1:0] PT_MASK = (ONE << (PT_HI + 1)) - (ONE << PT_LO);
    localparam logic [NUM_IRQ-1:0] STUCK_LOW = ~(PT_MASK | (ONE << CASC_IDX));

    logic [NUM_IRQ-1:0] out_nxt;
    logic               casc_nxt;

    // Purpose: merged pending indication from enabled sources.
    assign casc_nxt = |(irq_in & mask_q);

    // Purpose: per-line selection of cascade, pass-through or constant low.
    for (genvar b = 0; b < NUM_IRQ; b++) begin : g_line
        if (b == CASC_IDX) begin : g_casc
            assign out_nxt[b] = casc_nxt;
        end else if ((b >= PT_LO) && (b <= PT_HI)) begin : g_pass
            assign out_nxt[b] = irq_in[b] & pt_q[b];
        end else begin : g_low
            assign out_nxt[b] = 1'b0;
        end
    end

    // Purpose: register the output lines for a fixed one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= out_nxt;
    end

    AST_CASCADE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out[CASC_IDX] == |($past(irq_in) & $past(mask_q)))); // R7
    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_out & PT_MASK) == ($past(irq_in) & $past(pt_q) & PT_MASK))); // R8
    AST_LOW_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) || ((irq_out & STUCK_LOW) == '0)); // R8

endmodule

// File: rtl/irqsec_top.sv
// Module: irqsec_top
// Purpose: secondary interrupt controller top; ties the address decode,
// register file and output routing together.
// Assumes: one bus write per cycle with bus_wr high; inputs are synchronous.
module irqsec_top #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned PT_LO    = 21,
    parameter int unsigned PT_HI    = 30,
    parameter int unsigned CASC_IDX = 31,
    localparam int unsigned NUM_IRQ = 32,
    localparam int unsigned WORD_W  = ADDR_W - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [NUM_IRQ-1:0]   bus_wdata,
    output logic [NUM_IRQ-1:0]   bus_rdata,
    output logic [NUM_IRQ-1:0]   irq_out
);
    logic [WORD_W-1:0]    word_idx;
    irqsec_pkg::wr_op_t   wr_op;
    logic                 wdata_nz;
    logic                 undef_word;
    logic [NUM_IRQ-1:0]   raw_q;
    logic [NUM_IRQ-1:0]   mask_q;
    logic [NUM_IRQ-1:0]   pt_q;

    irqsec_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .word_idx   (word_idx),
        .wr_op      (wr_op),
        .wdata_nz   (wdata_nz),
        .undef_word (undef_word)
    );

    irqsec_regs #(
        .NUM_IRQ (NUM_IRQ),
        .ADDR_W  (ADDR_W),
        .PT_LO   (PT_LO),
        .PT_HI   (PT_HI)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .wdata      (bus_wdata),
        .word_idx   (word_idx),
        .wr_op      (wr_op),
        .wdata_nz   (wdata_nz),
        .undef_word (undef_word),
        .bus_wr     (bus_wr),
        .raw_q      (raw_q),
        .mask_q     (mask_q),
        .pt_q       (pt_q),
        .rdata      (bus_rdata)
    );

    irqsec_route #(
        .NUM_IRQ  (NUM_IRQ),
        .PT_LO    (PT_LO),
        .PT_HI    (PT_HI),
        .CASC_IDX (CASC_IDX)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .mask_q  (mask_q),
        .pt_q    (pt_q),
        .irq_out (irq_out)
    );

    logic unused_raw;
    assign unused_raw = &{1'b0, raw_q};

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> (irq_out == '0)); // R1

endmodule

// File: tb/irqsec_top_tb_top.sv
// Bench: sweeps every input line through the cascade and pass-through
// paths and every register word, with expected values computed here.
module irqsec_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PT_BAND = 32'h7FE0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_mask = '0;
    logic [31:0] exp_pt   = '0;

    irqsec_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int word, input logic [31:0] data);
        @(negedge clk);
        bus_addr = 12'(word << 2);
        bus_wdata = data;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd_check(input string req, input int word, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = 12'(word << 2);
        #1;
        check(req, bus_rdata, exp);
    endtask

    function automatic logic [31:0] exp_out(input logic [31:0] lv);
        return (lv & exp_pt & PT_BAND) | {(|(lv & exp_mask)), 31'b0};
    endfunction

    task automatic out_check(input string req, input logic [31:0] lv);
        @(negedge clk);
        irq_in = lv;
        @(negedge clk);
        check(req, irq_out, exp_out(lv));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        irq_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", irq_out, '0);
        rst_n = 1'b1;
        rd_check("R1 mask after reset", 2, '0);
        rd_check("R1 pt after reset", 8, '0);
        @(negedge clk);
        check("R1 outputs low with mask zero", irq_out, '0);

        // R7: one line at a time through the cascade
        for (int i = 0; i < 32; i++) begin
            wr(3, 32'hFFFF_FFFF); exp_mask = '0;
            wr(2, 32'h1 << i);    exp_mask = 32'h1 << i;
            rd_check("R3 enable set readback", 2, exp_mask);
            out_check("R7 cascade own line", 32'h1 << i);
            out_check("R7 cascade other lines", ~(32'h1 << i));
            rd_check("R2 raw level", 1, ~(32'h1 << i));
            rd_check("R2 masked status", 0, '0);
        end

        // R3: set ORs in, clear removes only selected bits
        wr(2, 32'hF0F0_F0F0); exp_mask |= 32'hF0F0_F0F0;
        wr(2, 32'h0000_FF00); exp_mask |= 32'h0000_FF00;
        rd_check("R3 set accumulates", 2, exp_mask);
        wr(3, 32'h3000_0300); exp_mask &= ~32'h3000_0300;
        rd_check("R3 clear selected", 2, exp_mask);
        out_check("R2 status setup", 32'h5A5A_A5A5);
        rd_check("R2 status masked", 0, 32'h5A5A_A5A5 & exp_mask);
        rd_check("R2 raw unmasked", 1, 32'h5A5A_A5A5);

        // R4: soft-interrupt words
        wr(3, 32'hFFFF_FFFF); exp_mask = '0;
        wr(4, 32'h0);
        rd_check("R4 zero set ignored", 2, '0);
        wr(4, 32'h8000_0000); exp_mask = 32'h1;
        rd_check("R4 nonzero set mask0", 2, 32'h1);
        out_check("R4 bit0 pending", 32'hFFFF_FFFF);
        rd_check("R4 read raw bit0", 4, 32'h1);
        wr(5, 32'h0);
        rd_check("R4 zero clear ignored", 2, 32'h1);
        wr(5, 32'h0000_0010); exp_mask = '0;
        rd_check("R4 nonzero clear mask0", 2, '0);
        out_check("R4 bit0 low", 32'hFFFF_FFFE);
        rd_check("R4 read raw bit0 zero", 4, '0);

        // R5/R8: pass-through band
        wr(8, 32'hFFFF_FFFF); exp_pt = PT_BAND;
        rd_check("R5 pt set limited to band", 8, PT_BAND);
        for (int i = 0; i < 32; i++) begin
            out_check("R8 pass-through single line", 32'h1 << i);
        end
        out_check("R8 all lines high", 32'hFFFF_FFFF);
        // R6: clear part of the band
        wr(9, 32'h2AA0_0000); exp_pt &= ~32'h2AA0_0000;
        rd_check("R6 pt clear selected", 8, exp_pt);
        out_check("R6 cleared lines go low", 32'hFFFF_FFFF);
        wr(8, 32'h0020_0001); exp_pt |= 32'h0020_0000;
        rd_check("R5 pt set outside band dropped", 8, exp_pt);
        wr(2, 32'h8000_0000); exp_mask = 32'h8000_0000;
        out_check("R7 cascade with pass-through", 32'h8000_0000);
        out_check("R8 low band stays low", 32'h001F_FFFF);

        // R9: undefined words
        for (int w = 6; w < 16; w++) begin
            if (w != 8 && w != 9) begin
                wr(w, 32'hFFFF_FFFF);
                rd_check("R9 undefined read zero", w, '0);
                rd_check("R9 mask untouched", 2, exp_mask);
                rd_check("R9 pt untouched", 8, exp_pt);
            end
        end
        wr(1023, 32'hFFFF_FFFF);
        rd_check("R9 top word read zero", 1023, '0);
        rd_check("R9 top write mask untouched", 2, exp_mask);
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'h0000_0000);
        rd_check("R9 read-only words ignore writes", 8, exp_pt);

        // R1: reset in mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_mask = '0; exp_pt = '0;
        rd_check("R1 mask cleared by reset", 2, '0);
        rd_check("R1 pt cleared by reset", 8, '0);
        out_check("R1 outputs low after reset", 32'hFFFF_FFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule